// File: doc/BRIEF.md
# Fiducial-Started Multichannel Delay Unit

This block is a bank of sixteen coarse delay channels running on the machine reference clock, nominally 119 MHz, so one count step is about 8.4 ns. A host writes a delay value into a channel through a simple write port. The write also arms that channel. Nothing starts at the write. When the shared fiducial pulse arrives, every armed channel starts its countdown on the same clock edge. When a channel's count expires, it drives one active-high pulse of fixed width on its trigger line.

Delay values are staged between fiducials. A value written while a channel is counting is held for the next fiducial and does not disturb the count in progress. Each fiducial consumes the arms it uses, so a channel must be written again to fire on a later fiducial. A fiducial that finds a channel still counting restarts that channel from its staged value and sets a sticky overrun flag. Per-channel busy, done and overrun outputs let the surrounding logic follow the state of each channel.

Top module: `fid_delay_bank`

## Requirements
- R1: After reset every trigger, busy, done and overrun output is 0.
- R2: When a channel with staged delay D is started by a fiducial edge sampled at clock edge E0, its trigger output rises after edge E0+D+1. D is the unsigned value of `wr_delay`, counted in clock cycles.
- R3: Every trigger pulse is active-high and stays high for exactly PW (default 8) clock cycles. `busy_o` of a channel is high from the start edge until the last cycle of its pulse.
- R4: A write only stages the value and arms the channel. A channel that is not armed and not counting ignores the fiducial, and a write without a fiducial produces no pulse and no busy.
- R5: A fiducial clears the arm of every channel it starts. A second fiducial with no new write fires nothing.
- R6: A write to a channel whose count is in progress leaves the current count unchanged. The new value is used at the next fiducial.
- R7: A delay of 0 raises the trigger after the clock edge that follows the edge sampling the fiducial.
- R8: A fiducial edge that arrives while a channel is still counting restarts that channel from its staged value and sets the channel's `overrun_o` bit. A write to that channel clears the bit.
- R9: `done_o` of a channel is set when its pulse starts and stays set until that channel is written again.
- R10: Only a rising edge of `fid_i` starts channels. Holding `fid_i` high for several cycles starts them once.
- R11: Delays use the full DW-bit (default 19-bit) range. The default covers more than 2.7 ms at 119 MHz. A value of 70000 fires on edge E0+70001.
- R12: All channels count independently and may fire in any overlapping pattern. `wr_sel` selects the channel by its binary index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one cycle is one delay step |
| rst_n | input | 1 | Active-low synchronous reset |
| fid_i | input | 1 | Common fiducial; its rising edge starts armed channels |
| wr_en | input | 1 | Write strobe for the delay staging port |
| wr_sel | input | AW (4) | Binary channel index for the write |
| wr_delay | input | DW (19) | Delay value in clock cycles |
| trig_o | output | NCH (16) | Active-high trigger pulses, one per channel |
| busy_o | output | NCH (16) | Channel counting or pulsing |
| done_o | output | NCH (16) | Sticky: channel has fired since its last write |
| overrun_o | output | NCH (16) | Sticky: fiducial arrived during a count |

## Verification
On every cycle, the embedded properties check the following. A count only begins on a fiducial edge. A trigger only rises after the count reached zero. The done flag only rises together with its trigger. An overrun only appears on a fiducial that met a running count. A fiducial always clears a channel's arm unless the channel was written in the same cycle. Exact delay-to-pulse timing, the fixed width, the hand-over of a value written mid-count and the restart point after an overrun depend on the values involved. Only the bench scenarios show these, with a model that predicts each trigger line and busy line cycle by cycle for random and directed delays.

// File: rtl/fid_delay_bank.sv
module fid_delay_bank #(
  parameter int NCH = 16,
  parameter int DW  = 19,
  parameter int PW  = 8,
  localparam int AW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fid_i,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_sel,
  input  logic [DW-1:0]  wr_delay,
  output logic [NCH-1:0] trig_o,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] done_o,
  output logic [NCH-1:0] overrun_o
);
  localparam int PCW = $clog2(PW + 1);

  logic fid_d;
  logic start;

  always_ff @(posedge clk) begin
    if (!rst_n) fid_d <= 1'b0;
    else        fid_d <= fid_i;
  end

  assign start = fid_i & ~fid_d;

  logic [DW-1:0]  dly_q [NCH];
  logic [DW-1:0]  cnt_q [NCH];
  logic [PCW-1:0] pw_q  [NCH];
  logic [NCH-1:0] arm_q, run_q, done_q, ovr_q, wr_hit, go, expire;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_hit[i] = wr_en && (wr_sel == AW'(i));
    assign go[i]     = start && (arm_q[i] || run_q[i]);
    assign expire[i] = run_q[i] && (cnt_q[i] == '0) && !go[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly_q[i]  <= '0;
        cnt_q[i]  <= '0;
        pw_q[i]   <= '0;
        arm_q[i]  <= 1'b0;
        run_q[i]  <= 1'b0;
        done_q[i] <= 1'b0;
        ovr_q[i]  <= 1'b0;
      end else begin
        if (wr_hit[i]) dly_q[i] <= wr_delay;
        arm_q[i] <= wr_hit[i] | (arm_q[i] & ~start);

        if (go[i]) begin
          cnt_q[i] <= dly_q[i];
          run_q[i] <= 1'b1;
        end else if (run_q[i]) begin
          if (cnt_q[i] == '0) run_q[i] <= 1'b0;
          else                cnt_q[i] <= cnt_q[i] - DW'(1);
        end

        if (expire[i])           pw_q[i] <= PCW'(PW);
        else if (pw_q[i] != '0)  pw_q[i] <= pw_q[i] - PCW'(1);

        if (wr_hit[i])      done_q[i] <= 1'b0;
        else if (expire[i]) done_q[i] <= 1'b1;

        if (wr_hit[i])                ovr_q[i] <= 1'b0;
        else if (start && run_q[i])   ovr_q[i] <= 1'b1;
      end
    end

    assign trig_o[i]    = (pw_q[i] != '0);
    assign busy_o[i]    = run_q[i] | trig_o[i];
    assign done_o[i]    = done_q[i];
    assign overrun_o[i] = ovr_q[i];

    AST_START_ON_FID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[i]) |-> $past(start));                                  // R4
    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_o[i]) |-> $past(run_q[i] && cnt_q[i] == '0));             // R2
    AST_DONE_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o[i]) |-> trig_o[i]);                                     // R9
    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun_o[i]) |-> $past(start && run_q[i]));                   // R8
    AST_ARM_USED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(start) && !$past(wr_hit[i])) |-> !arm_q[i]);                  // R5
  end
endmodule

// File: tb/fid_delay_bank_test.sv
`timescale 1ns/1ps
module fid_delay_bank_test;
  localparam int NCH = 16;
  localparam int DW  = 19;
  localparam int PW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fid_i = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_sel = '0;
  logic [DW-1:0] wr_delay = '0;
  logic [NCH-1:0] trig_o, busy_o, done_o, overrun_o;

  always #2.5 clk = ~clk;

  fid_delay_bank #(.NCH(NCH), .DW(DW), .PW(PW)) uut (
    .clk(clk), .rst_n(rst_n), .fid_i(fid_i), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_delay(wr_delay), .trig_o(trig_o), .busy_o(busy_o), .done_o(done_o),
    .overrun_o(overrun_o));

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int m_d [NCH];
  bit [NCH-1:0] m_arm = '0;
  bit [NCH-1:0] m_done = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit on_pulse(int d, int k);
    return (k >= d + 1) && (k <= d + PW);
  endfunction

  function automatic bit in_busy(int d, int k);
    return (k >= 0) && (k <= d + PW);
  endfunction

  task automatic hw_write(int ch, int d);
    wr_en = 1'b1; wr_sel = 4'(ch); wr_delay = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
    m_d[ch] = d; m_arm[ch] = 1'b1; m_done[ch] = 1'b0;
  endtask

  task automatic fire(string req, int win, int hold, int mid_k, int mid_ch, int mid_d);
    bit [NCH-1:0] act;
    int dd [NCH];
    bit [NCH-1:0] et, eb;
    act = m_arm;
    for (int c = 0; c < NCH; c++) dd[c] = m_d[c];
    m_arm = '0;
    fid_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k < win; k++) begin
      for (int c = 0; c < NCH; c++) begin
        et[c] = act[c] && on_pulse(dd[c], k);
        eb[c] = act[c] && in_busy(dd[c], k);
      end
      chk(trig_o == et, req, $sformatf("trig k=%0d", k), trig_o, et);
      chk(busy_o == eb, req, $sformatf("busy k=%0d", k), busy_o, eb);
      fid_i = (k < hold - 1);
      if (k == mid_k) begin
        wr_en = 1'b1; wr_sel = 4'(mid_ch); wr_delay = DW'(mid_d);
        m_d[mid_ch] = mid_d; m_arm[mid_ch] = 1'b1; m_done[mid_ch] = 1'b0;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    fid_i = 1'b0;
    m_done |= act;
    chk(done_o == m_done, "R9", "done after window", done_o, m_done);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    for (int c = 0; c < NCH; c++) m_d[c] = 0;
    repeat (3) @(negedge clk);
    chk(trig_o == '0 && busy_o == '0, "R1", "trig/busy in reset", {trig_o, busy_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(trig_o == '0 && busy_o == '0 && done_o == '0 && overrun_o == '0, "R1",
        "outputs after reset", {trig_o, busy_o, done_o, overrun_o}, 0);

    // R4: write alone starts nothing
    hw_write(3, 5);
    for (int k = 0; k < 20; k++) begin
      chk(trig_o == '0 && busy_o == '0, "R4", "no start without fiducial", {trig_o, busy_o}, 0);
      @(negedge clk);
    end
    fire("R4 R2 R3", 20, 1, -1, 0, 0);

    // R5: arms consumed
    fire("R5", 30, 1, -1, 0, 0);

    // R7: zero delay on two channels
    hw_write(0, 0);
    hw_write(9, 0);
    fire("R7 R3", 15, 1, -1, 0, 0);

    // R12: every channel with its own delay
    for (int c = 0; c < NCH; c++) hw_write(c, c * 3);
    fire("R12 R2", 3 * NCH + PW + 4, 1, -1, 0, 0);

    // R10: fiducial held high for five cycles
    hw_write(4, 2);
    hw_write(7, 11);
    fire("R10", 30, 5, -1, 0, 0);

    // R6: write during count, new value at next fiducial
    hw_write(2, 10);
    fire("R6", 25, 1, 3, 2, 4);
    fire("R6", 20, 1, -1, 0, 0);

    // R8: fiducial during count restarts and flags overrun
    hw_write(5, 30);
    m_arm[5] = 1'b0;
    fid_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 55; k++) begin
      bit e;
      e = on_pulse(30, k - 10);
      chk(trig_o[5] == e && trig_o[4:0] == '0 && trig_o[15:6] == '0, "R8",
          $sformatf("restart trig k=%0d", k), trig_o, e ? 32'h20 : 0);
      fid_i = (k == 9);
      @(negedge clk);
    end
    fid_i = 1'b0;
    m_done[5] = 1'b1;
    chk(overrun_o == 16'h0020, "R8", "overrun sticky", overrun_o, 16'h0020);
    hw_write(5, 1);
    chk(overrun_o == '0, "R8", "overrun cleared by write", overrun_o, 0);
    chk(done_o[5] == 1'b0, "R9", "done cleared by write", done_o[5], 0);
    fire("R8 R2", 15, 1, -1, 0, 0);

    // randomized rounds
    for (int r = 0; r < 25; r++) begin
      for (int c = 0; c < NCH; c++)
        if ($urandom_range(1, 0) == 1) hw_write(c, int'($urandom_range(40, 0)));
      fire("R2 R3 R12", 40 + PW + 4, int'($urandom_range(3, 1)), -1, 0, 0);
    end

    // R11: long delay
    hw_write(15, 70000);
    m_arm[15] = 1'b0;
    fid_i = 1'b1;
    @(negedge clk);
    fid_i = 1'b0;
    for (int k = 0; k < 70012; k++) begin
      if (k == 70000)
        chk(trig_o[15] == 1'b0 && busy_o[15] == 1'b1, "R11", "just before expiry",
            {trig_o[15], busy_o[15]}, 2'b01);
      if (k == 70001)
        chk(trig_o[15] == 1'b1, "R11", "fires at D+1", trig_o[15], 1);
      if (k == 70009)
        chk(trig_o[15] == 1'b0 && busy_o[15] == 1'b0, "R11 R3", "pulse ended",
            {trig_o[15], busy_o[15]}, 0);
      @(negedge clk);
    end
    chk(done_o[15] == 1'b1, "R11", "done after long delay", done_o[15], 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule